// File: doc/BRIEF.md
# Triangle-Ramp Pulse Height Digitizer

The block drives a digital triangle code to a digital-to-analog converter and watches a single comparator bit. That bit flips each time the analog triangle passes the level of the input pulse. When a flip is seen, the block reports the triangle code at the clock on which the flip happened. That code is the pulse height, so no time-to-amplitude conversion is needed. A single slow pulse is crossed twice: once while the ramp climbs and once while it falls. Each report carries a slope bit so that downstream logic can pair the two crossings.

The ramp leaves reset at 0 and climbs by one per enabled clock. It turns at the top code straight back down, then turns at 1 straight back up, with no dwell at either end. After the first rise the pattern repeats every 2·(2^W−2) clocks (508 clocks for 8 bits). The comparator is asynchronous to the clock. It passes through a synchronizer, and the captured code is taken from an equally delayed copy of the ramp, so the reported height is still the code at the crossing clock.

Top module: `phd_digitizer`

## Requirements
- R1: While rst_n is low, ref_code, height, height_dir and height_vld are all 0.
- R2: After reset, the n-th clock with en high sets ref_code to n, for n from 1 to 255.
- R3: At 255 the ramp turns without dwelling. The next enabled clock gives 254, and the codes then fall by one per enabled clock.
- R4: At 1 on the falling leg the ramp turns without dwelling. The next enabled clock gives 2. From the first 1 onward the code sequence repeats with a period of 508 enabled clocks.
- R5: A clock with en low leaves ref_code unchanged, and the ramp resumes from that code when en returns high.
- R6: Every level change of comp_in, rising or falling, is reported. Suppose comp_in changes between the clock edge that set ref_code to value c and the next edge. Then height_vld is high after the third edge following the one that set c, and height equals c.
- R7: height_vld is high for exactly one clock per reported change. Between reports, height and height_dir keep their last values.
- R8: height_dir is 1 when the captured code was reached by an upward step and 0 when it was reached by a downward step.
- R9: height_vld stays low on every clock where en was low. Comparator changes that settle while en is low are never reported afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| en | input | 1 | Clock enable for the ramp; also gates reports |
| comp_in | input | 1 | Asynchronous comparator output (triangle vs. pulse level) |
| ref_code | output | 8 | Triangle code to the digital-to-analog converter |
| height | output | 8 | Last captured pulse height |
| height_dir | output | 1 | Slope of the ramp at the captured code (1 = rising) |
| height_vld | output | 1 | One-clock strobe marking a new height |

## Verification
A wrong ramp state shows on ref_code on the very next enabled clock. A missed turn shows as 0 or 256-wrap where 254 or 2 was due, and a lost slope bit flips height_dir in the following reports. A wrong synchronizer or history depth shifts every reported height by one code and moves height_vld off its slot three clocks after the crossing. A stuck edge detector shows as a missing or doubled strobe. The comparator is modelled from ref_code against every level from 0 to 254, so each turn point and each slope pairing is crossed on both legs.

// File: rtl/phd_pkg.sv
package phd_pkg;

  // Direction of the step that produced the present ramp code.
  typedef enum logic {
    SLOPE_DOWN = 1'b0,
    SLOPE_UP   = 1'b1
  } slope_e;

endpackage

// File: rtl/phd_ramp_gen.sv
module phd_ramp_gen
  import phd_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [CODE_W-1:0] code_o,
  output slope_e            slope_o
);

  localparam logic [CODE_W-1:0] STEP   = CODE_W'(1);
  localparam logic [CODE_W-1:0] TOP    = '1;
  localparam logic [CODE_W-1:0] BOTTOM = CODE_W'(1);

  logic [CODE_W-1:0] code_q, code_d;
  slope_e            slope_q, slope_d;

  // Next state: turn around at either end without a repeated code.
  always_comb begin
    code_d  = code_q;
    slope_d = slope_q;
    if (slope_q == SLOPE_UP) begin
      if (code_q == TOP) begin
        code_d  = code_q - STEP;
        slope_d = SLOPE_DOWN;
      end else begin
        code_d  = code_q + STEP;
      end
    end else begin
      if (code_q == BOTTOM) begin
        code_d  = code_q + STEP;
        slope_d = SLOPE_UP;
      end else begin
        code_d  = code_q - STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      slope_q <= SLOPE_UP;
    end else if (en) begin
      code_q  <= code_d;
      slope_q <= slope_d;
    end
  end

  assign code_o  = code_q;
  assign slope_o = slope_q;

endmodule

// File: rtl/phd_sync_edge.sv
module phd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  // Either direction of change counts.
  assign edge_o = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/phd_capture.sv
module phd_capture
  import phd_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int DELAY  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code_i,
  input  slope_e            slope_i,
  input  logic              edge_i,
  output logic [CODE_W-1:0] height_o,
  output logic              dir_o,
  output logic              vld_o
);

  // Ramp history matching the synchronizer delay.
  logic [CODE_W-1:0] code_hist [DELAY];
  slope_e            slope_hist[DELAY];

  generate
    for (genvar d = 0; d < DELAY; d++) begin : g_hist
      if (d == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            code_hist[d]  <= '0;
            slope_hist[d] <= SLOPE_UP;
          end else begin
            code_hist[d]  <= code_i;
            slope_hist[d] <= slope_i;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            code_hist[d]  <= '0;
            slope_hist[d] <= SLOPE_UP;
          end else begin
            code_hist[d]  <= code_hist[d-1];
            slope_hist[d] <= slope_hist[d-1];
          end
        end
      end
    end
  endgenerate

  logic [CODE_W-1:0] height_q, height_d;
  logic              dir_q, dir_d;
  logic              vld_q, vld_d;
  logic              take;

  always_comb begin
    take     = edge_i & en;
    vld_d    = take;
    height_d = height_q;
    dir_d    = dir_q;
    if (take) begin
      height_d = code_hist[DELAY-1];
      dir_d    = (slope_hist[DELAY-1] == SLOPE_UP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      height_q <= '0;
      dir_q    <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      height_q <= height_d;
      dir_q    <= dir_d;
      vld_q    <= vld_d;
    end
  end

  assign height_o = height_q;
  assign dir_o    = dir_q;
  assign vld_o    = vld_q;

endmodule

// File: rtl/phd_digitizer.sv
module phd_digitizer
  import phd_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              comp_in,
  output logic [CODE_W-1:0] ref_code,
  output logic [CODE_W-1:0] height,
  output logic              height_dir,
  output logic              height_vld
);

  // The captured code must be as old as the comparator path is long.
  localparam int HIST_DEPTH = SYNC_STAGES;

  logic [CODE_W-1:0] ramp_code;
  slope_e            ramp_slope;
  logic              cmp_edge;

  phd_ramp_gen #(
    .CODE_W (CODE_W)
  ) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .code_o  (ramp_code),
    .slope_o (ramp_slope)
  );

  phd_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (comp_in),
    .edge_o (cmp_edge)
  );

  phd_capture #(
    .CODE_W (CODE_W),
    .DELAY  (HIST_DEPTH)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .code_i   (ramp_code),
    .slope_i  (ramp_slope),
    .edge_i   (cmp_edge),
    .height_o (height),
    .dir_o    (height_dir),
    .vld_o    (height_vld)
  );

  assign ref_code = ramp_code;

endmodule

// File: rtl/phd_digitizer_chk.sv
module phd_digitizer_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [CODE_W-1:0] ref_code,
  input logic [CODE_W-1:0] height,
  input logic              height_dir,
  input logic              height_vld
);

  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);
  localparam logic [CODE_W-1:0] TOP = '1;

  // R2 R3 R4: each enabled clock moves the ramp by exactly one code.
  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (ref_code == $past(ref_code) + ONE) || (ref_code == $past(ref_code) - ONE));

  assert_top_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ref_code == TOP) |=> ref_code == TOP - ONE);

  assert_bottom_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ref_code == ONE) |=> ref_code == ONE + ONE);

  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ref_code));

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((height != $past(height)) || (height_dir != $past(height_dir))) |-> height_vld);

  assert_top_is_rising_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (height_vld && height == TOP) |-> height_dir);

  assert_no_strobe_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    height_vld |-> $past(en));

endmodule

bind phd_digitizer phd_digitizer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .ref_code   (ref_code),
  .height     (height),
  .height_dir (height_dir),
  .height_vld (height_vld)
);

// File: tb/phd_digitizer_tb.sv
module phd_digitizer_tb;

  localparam int W      = 8;
  localparam int TOPV   = (1 << W) - 1;
  localparam int PERIOD = 2 * (TOPV - 1);
  localparam int RUN    = 520;
  localparam int LAT    = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         drive_cmp = 1'b1;
  logic         cmp_model = 1'b0;
  logic         manual_cmp = 1'b0;
  logic         comp_in;
  logic [W-1:0] ref_code, height;
  logic         height_dir, height_vld;

  int total = 0;
  int bad   = 0;
  int level = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  assign comp_in = drive_cmp ? cmp_model : manual_cmp;

  // Behavioural comparator: high while the triangle is above the level.
  always @(negedge clk) cmp_model <= (int'(ref_code) > level);

  phd_digitizer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .comp_in    (comp_in),
    .ref_code   (ref_code),
    .height     (height),
    .height_dir (height_dir),
    .height_vld (height_vld)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int n);
    int m;
    if (n == 0) return 0;
    m = (n - 1) % PERIOD;
    if (m <= TOPV - 1) return 1 + m;
    return 2 * TOPV - 1 - m;
  endfunction

  task automatic do_reset();
    en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_level(input int lv);
    bit ev_v [RUN + LAT + 1];
    int ev_h [RUN + LAT + 1];
    bit ev_d [RUN + LAT + 1];
    int ramp_err = 0, ev_err = 0, hold_err = 0, seen = 0;
    int last_h = 0, last_d = 0;
    for (int i = 0; i <= RUN + LAT; i++) begin
      ev_v[i] = 0; ev_h[i] = 0; ev_d[i] = 0;
    end
    drive_cmp = 1'b1;
    level = lv;
    do_reset();
    en = 1'b1;
    for (int n = 1; n <= RUN; n++) begin
      bit cn, cp;
      @(negedge clk);
      if (int'(ref_code) != exp_code(n)) begin
        if (ramp_err == 0)
          $display("FAIL R2 R3 R4 ramp level=%0d n=%0d actual=%0d expected=%0d",
                   lv, n, ref_code, exp_code(n));
        ramp_err++;
      end
      cn = exp_code(n) > lv;
      cp = exp_code(n - 1) > lv;
      if (cn != cp) begin
        ev_v[n + LAT] = 1;
        ev_h[n + LAT] = exp_code(n);
        ev_d[n + LAT] = exp_code(n) > exp_code(n - 1);
      end
      if (height_vld != ev_v[n]) begin
        if (ev_err == 0)
          $display("FAIL R6 R7 strobe level=%0d n=%0d actual=%0d expected=%0d",
                   lv, n, height_vld, ev_v[n]);
        ev_err++;
      end else if (ev_v[n]) begin
        seen++;
        if (int'(height) != ev_h[n] || int'(height_dir) != int'(ev_d[n])) begin
          if (ev_err == 0)
            $display("FAIL R6 R8 capture level=%0d n=%0d actual=%0d/%0d expected=%0d/%0d",
                     lv, n, height, height_dir, ev_h[n], ev_d[n]);
          ev_err++;
        end
        last_h = ev_h[n];
        last_d = int'(ev_d[n]);
      end else if (int'(height) != last_h || int'(height_dir) != last_d) begin
        hold_err++;
      end
    end
    check(ramp_err == 0, "R2 R3 R4 ramp sequence", ramp_err, 0);
    check(ev_err == 0, "R6 R8 crossing reports", ev_err, 0);
    check(hold_err == 0, "R7 hold between reports", hold_err, 0);
    check(seen >= 1, "R6 crossing count", seen, 1);
  endtask

  task automatic run_disable();
    int err = 0;
    drive_cmp = 1'b0;
    manual_cmp = 1'b0;
    level = 0;
    do_reset();
    en = 1'b1;
    repeat (20) @(negedge clk);
    check(int'(ref_code) == 20, "R2 count before freeze", ref_code, 20);
    en = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (k % 3 == 0) manual_cmp = ~manual_cmp;
      @(negedge clk);
      if (int'(ref_code) != 20 || height_vld) err++;
    end
    manual_cmp = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (int'(ref_code) != 20 || height_vld) err++;
    end
    check(err == 0, "R5 R9 frozen and silent", err, 0);
    en = 1'b1;
    @(negedge clk);
    check(int'(ref_code) == 21, "R5 resume", ref_code, 21);
    err = 0;
    repeat (10) begin
      @(negedge clk);
      if (height_vld) err++;
    end
    check(err == 0, "R9 no late report", err, 0);
    check(int'(height) == 0, "R9 height untouched", height, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(ref_code == '0, "R1 ref_code in reset", ref_code, 0);
    check(height == '0, "R1 height in reset", height, 0);
    check(height_dir == 1'b0, "R1 height_dir in reset", height_dir, 0);
    check(height_vld == 1'b0, "R1 height_vld in reset", height_vld, 0);
    run_disable();
    for (int lv = 0; lv < TOPV; lv++) run_level(lv);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule